// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by running a down counter that must be serviced before it runs out. Once software sets the enable bit, the counter starts from the programmed timeout value and steps down on ticks taken from one of four slow clock inputs. The selected input passes through a synchronizer and a programmable divider. Software services the block by writing a two-word unlock sequence to a service register. If the counter reaches zero first, a one-cycle timeout reset pulse is raised.

Two optional protections tighten this. When windowing is on, a service that arrives too early, while the counter is still above the window value, raises a window reset and does not reload the counter. An interrupt warns software once the counter has fallen to a programmable level. A separate reference-loss path raises its own reset a fixed number of bus cycles after a strobe on the reference-lost input. Debug, wait and stop inputs can freeze the count. After enable the configuration locks until the block reset. Each reset cause sets a sticky bit that software clears by writing 1 to it.

Register map (word addresses): 0 control, 1 timeout value, 2 window value, 3 interrupt level, 4 divider, 5 service, 6 live count (read only), 7 cause. Control bits: bit0 enable, bit1 window enable, bit2 run in wait, bit3 run in stop, bits 5:4 clock select, bit6 interrupt enable.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the count (address 6) and the timeout (address 1) read 0xFFFF, the cause register (address 7) reads 0, and all reset outputs and irq_o are low.
- R2: Once enabled, the counter loads the timeout value T and steps down by one per tick. On the tick that finds it at zero it raises rst_timeout_o for exactly one cycle and reloads T, so the timeout comes T+1 ticks after the load.
- R3: Ticks are rising edges of src_clk_i[sel], where sel is control bits 5:4, divided by (divider value + 1).
- R4: A valid service while enabled reloads the counter with the timeout value and prevents the timeout.
- R5: A service is a write of 0x5555 to address 5 followed directly by a write of 0xAAAA to address 5. Any other value written to address 5 in between cancels the pending unlock, and the following 0xAAAA has no effect.
- R6: With window enable (control bit1) set, a valid service while the count is greater than the window value raises rst_window_o for one cycle and does not reload. A service at or below the window value reloads normally.
- R7: With window enable clear, a valid service reloads at any count and never raises rst_window_o.
- R8: irq_o is high while enabled, interrupt enable (control bit6) is set and the count is at or below the interrupt level. It falls when a service reloads the counter above that level.
- R9: While dbg_i is high the count holds its value, and it resumes when dbg_i falls.
- R10: While wait_i is high the count holds unless control bit2 is set. While stop_i is high the count holds unless control bit3 is set.
- R11: rst_refloss_o pulses for one cycle 128 clk_i cycles after the clock edge that samples ref_lost_i high, whether or not the watchdog is enabled.
- R12: After enable, writes to addresses 0 to 4 are ignored until rst_ni. The readback keeps the old values, and enable cannot be cleared.
- R13: Cause bit0 (timeout), bit1 (window) and bit2 (reference loss) set on their pulses and stay set until software writes 1 to that bit of address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 4 | Candidate counter clock inputs, sampled in the bus domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Combinational read data |
| dbg_i | input | 1 | Debug halt, freezes counting |
| wait_i | input | 1 | Wait mode indication |
| stop_i | input | 1 | Stop mode indication |
| ref_lost_i | input | 1 | Reference-loss strobe |
| irq_o | output | 1 | Early warning interrupt |
| rst_timeout_o | output | 1 | Timeout reset pulse |
| rst_window_o | output | 1 | Early-service reset pulse |
| rst_refloss_o | output | 1 | Reference-loss reset pulse |

## Verification
The properties assume that each source clock holds every level for at least two bus cycles, so that the synchronizer sees every edge. They also assume that ref_lost_i is not raised again while a reference-loss delay is still running, and that each register write lasts one cycle. The stimulus takes the sources from a divider in the bench whose fastest output has a period of four bus cycles. It pulses the reference-loss strobe once, drives each write for one cycle, and sets mode inputs only on falling edges. Because the synchronizer adds a phase that the bench cannot see, periods are checked against a band one tick wide.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int NUM_SRC = 4;
   localparam int SEL_W   = 2;

   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_TOUT  = 3'd1,
      REG_WIN   = 3'd2,
      REG_IRQ   = 3'd3,
      REG_PRE   = 3'd4,
      REG_SVC   = 3'd5,
      REG_CNT   = 3'd6,
      REG_CAUSE = 3'd7
   } reg_addr_e;

   // first member is the MSB: enable lands on bit 0, irq_en on bit 6
   typedef struct packed {
      logic             irq_en;
      logic [SEL_W-1:0] src_sel;
      logic             run_stop;
      logic             run_wait;
      logic             win_en;
      logic             enable;
   } ctrl_t;

   localparam int CAUSE_W = 3;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
   parameter int NSRC  = 4,
   parameter int PRE_W = 8,
   localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NSRC-1:0]  src_i,
   input  logic [SW-1:0]    sel_i,
   input  logic [PRE_W-1:0] pre_i,
   input  logic             run_i,
   output logic             tick_o
);
   logic [NSRC-1:0]  rise;
   logic [PRE_W-1:0] div_q;

   for (genvar g = 0; g < NSRC; g++) begin : g_sync
      logic [2:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q <= '0;
         else         sh_q <= {sh_q[1:0], src_i[g]};
      end
      assign rise[g] = sh_q[1] & ~sh_q[2];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (run_i && rise[sel_i]) begin
         if (div_q == pre_i) div_q <= '0;
         else                div_q <= div_q + 1'b1;
      end
   end

   assign tick_o = run_i & rise[sel_i] & (div_q == pre_i);
endmodule

// File: rtl/wdg_unlock.sv
module wdg_unlock #(
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              stb_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              svc_o
);
   localparam logic [DATA_W-1:0] KEY_ARM  = {(DATA_W/2){2'b01}};
   localparam logic [DATA_W-1:0] KEY_FIRE = ~KEY_ARM;

   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    armed_q <= 1'b0;
      else if (stb_i) armed_q <= (data_i == KEY_ARM);
   end

   assign svc_o = stb_i & armed_q & (data_i == KEY_FIRE);
endmodule

// File: rtl/wdg_lor_timer.sv
module wdg_lor_timer #(
   parameter int DLY = 128,
   localparam int CW = $clog2(DLY)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lost_i,
   output logic rst_o
);
   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         rst_o  <= 1'b0;
      end else begin
         rst_o <= 1'b0;
         if (busy_q) begin
            if (cnt_q == CW'(DLY - 1)) begin
               rst_o  <= 1'b1;
               busy_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
         end else if (lost_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
   import wdg_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int LOR_DLY     = 128,
   parameter bit WIN_SUPPORT = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_clk_i,
   input  logic               wr_en_i,
   input  logic [2:0]         wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic [2:0]         rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic               dbg_i,
   input  logic               wait_i,
   input  logic               stop_i,
   input  logic               ref_lost_i,
   output logic               irq_o,
   output logic               rst_timeout_o,
   output logic               rst_window_o,
   output logic               rst_refloss_o
);
   localparam int CTRL_W = $bits(ctrl_t);

   if (CNT_W > DATA_W || CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must lie between 4 and DATA_W");
   end
   if (PRE_W > DATA_W || CTRL_W > DATA_W || (DATA_W % 2) != 0) begin : g_bad_data
      $error("DATA_W must be even and hold every register field");
   end
   if (LOR_DLY < 2) begin : g_bad_lor
      $error("LOR_DLY must be at least 2");
   end

   ctrl_t             ctrl_q;
   ctrl_t             ctrl_new;
   logic [CNT_W-1:0]  tout_q, win_q, irq_lvl_q, cnt_q;
   logic [PRE_W-1:0]  pre_q;
   logic [CAUSE_W-1:0] cause_q;
   reg_addr_e         waddr, raddr;
   logic wr_cfg, svc_stb, clr_we, en_load, run, tick;
   logic svc_pulse, svc_fire, svc_ok, win_fail, to_hit;

   assign waddr    = reg_addr_e'(wr_addr_i);
   assign raddr    = reg_addr_e'(rd_addr_i);
   assign ctrl_new = ctrl_t'(wr_data_i[CTRL_W-1:0]);
   assign wr_cfg   = wr_en_i & ~ctrl_q.enable;
   assign svc_stb  = wr_en_i & (waddr == REG_SVC);
   assign clr_we   = wr_en_i & (waddr == REG_CAUSE);
   assign en_load  = wr_cfg & (waddr == REG_CTRL) & ctrl_new.enable;
   assign run      = ctrl_q.enable & ~dbg_i
                   & ~(wait_i & ~ctrl_q.run_wait)
                   & ~(stop_i & ~ctrl_q.run_stop);

   wdg_tick_gen #(.NSRC(NUM_SRC), .PRE_W(PRE_W)) i_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_clk_i),
      .sel_i  (ctrl_q.src_sel),
      .pre_i  (pre_q),
      .run_i  (run),
      .tick_o (tick)
   );

   wdg_unlock #(.DATA_W(DATA_W)) i_unlock (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (svc_stb),
      .data_i (wr_data_i),
      .svc_o  (svc_pulse)
   );

   wdg_lor_timer #(.DLY(LOR_DLY)) i_lor (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lost_i (ref_lost_i),
      .rst_o  (rst_refloss_o)
   );

   assign svc_fire = svc_pulse & ctrl_q.enable;

   if (WIN_SUPPORT) begin : g_win
      assign win_fail = svc_fire & ctrl_q.win_en & (cnt_q > win_q);
   end else begin : g_nowin
      assign win_fail = 1'b0;
   end

   assign svc_ok = svc_fire & ~win_fail;
   assign to_hit = tick & (cnt_q == '0) & ~svc_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q    <= '0;
         tout_q    <= '1;
         win_q     <= '1;
         irq_lvl_q <= '0;
         pre_q     <= '0;
      end else if (wr_cfg) begin
         case (waddr)
            REG_CTRL: ctrl_q    <= ctrl_new;
            REG_TOUT: tout_q    <= wr_data_i[CNT_W-1:0];
            REG_WIN:  win_q     <= wr_data_i[CNT_W-1:0];
            REG_IRQ:  irq_lvl_q <= wr_data_i[CNT_W-1:0];
            REG_PRE:  pre_q     <= wr_data_i[PRE_W-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '1;
      else if (en_load || svc_ok) cnt_q <= tout_q;
      else if (tick)              cnt_q <= (cnt_q == '0) ? tout_q : cnt_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rst_timeout_o <= 1'b0;
         rst_window_o  <= 1'b0;
      end else begin
         rst_timeout_o <= to_hit;
         rst_window_o  <= win_fail;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q <= '0;
      else cause_q <= (cause_q & ~(clr_we ? wr_data_i[CAUSE_W-1:0] : '0))
                    | {rst_refloss_o, win_fail, to_hit};
   end

   assign irq_o = ctrl_q.enable & ctrl_q.irq_en & (cnt_q <= irq_lvl_q);

   always_comb begin
      case (raddr)
         REG_CTRL:  rd_data_o = DATA_W'(ctrl_q);
         REG_TOUT:  rd_data_o = DATA_W'(tout_q);
         REG_WIN:   rd_data_o = DATA_W'(win_q);
         REG_IRQ:   rd_data_o = DATA_W'(irq_lvl_q);
         REG_PRE:   rd_data_o = DATA_W'(pre_q);
         REG_CNT:   rd_data_o = DATA_W'(cnt_q);
         REG_CAUSE: rd_data_o = DATA_W'(cause_q);
         default:   rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int CNT_W       = 16,
   parameter int LOR_DLY     = 128,
   parameter bit WIN_SUPPORT = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             dbg_i,
   input logic             ref_lost_i,
   input logic             en_q,
   input logic             win_en,
   input logic             svc_fire,
   input logic             svc_ok,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] win_q,
   input logic [CNT_W-1:0] tout_q,
   input logic             rst_timeout_o,
   input logic             rst_window_o,
   input logic             rst_refloss_o,
   input logic [2:0]       cause_q,
   input logic             clr_we,
   input logic [2:0]       clr_bits
);
   localparam int LW = $clog2(LOR_DLY + 1) + 1;
   logic          lor_busy;
   logic [LW-1:0] lor_age;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lor_busy <= 1'b0;
         lor_age  <= '0;
      end else if (rst_refloss_o) begin
         lor_busy <= ref_lost_i;
         lor_age  <= '0;
      end else if (lor_busy) begin
         lor_age <= lor_age + 1'b1;
      end else if (ref_lost_i) begin
         lor_busy <= 1'b1;
         lor_age  <= '0;
      end
   end

   // R2
   timeout_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_timeout_o |-> ($past(cnt_q) == '0));

   // R4
   service_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      svc_ok |=> (cnt_q == $past(tout_q)));

   // R6
   early_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (WIN_SUPPORT && svc_fire && win_en && (cnt_q > win_q)) |=> (rst_window_o && $stable(cnt_q)));

   // R9
   debug_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_i && en_q && !svc_ok) |=> $stable(cnt_q));

   // R11
   refloss_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_refloss_o |-> (lor_busy && (lor_age == LW'(LOR_DLY))));

   // R13
   cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_q[0] && !(clr_we && clr_bits[0])) |=> cause_q[0]);
endmodule

bind svc_watchdog wdg_chk #(
   .CNT_W(CNT_W), .LOR_DLY(LOR_DLY), .WIN_SUPPORT(WIN_SUPPORT)
) i_wdg_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .dbg_i         (dbg_i),
   .ref_lost_i    (ref_lost_i),
   .en_q          (ctrl_q.enable),
   .win_en        (ctrl_q.win_en),
   .svc_fire      (svc_fire),
   .svc_ok        (svc_ok),
   .cnt_q         (cnt_q),
   .win_q         (win_q),
   .tout_q        (tout_q),
   .rst_timeout_o (rst_timeout_o),
   .rst_window_o  (rst_window_o),
   .rst_refloss_o (rst_refloss_o),
   .cause_q       (cause_q),
   .clr_we        (clr_we),
   .clr_bits      (wr_data_i[2:0])
);

// File: tb/test_svc_watchdog.sv
module test_svc_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bcnt = '0;
   logic [3:0]  src_clk;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic dbg = 1'b0, wt = 1'b0, stp = 1'b0, lost = 1'b0;
   logic irq, rst_to, rst_win, rst_rf;
   int n_chk = 0, n_fail = 0, n_win = 0, n_rf = 0;

   always #4 clk = ~clk;
   always @(negedge clk) bcnt <= bcnt + 1'b1;
   assign src_clk = bcnt[4:1];
   always @(negedge clk) begin
      if (rst_win) n_win++;
      if (rst_rf)  n_rf++;
   end

   svc_watchdog i_svc_watchdog (
      .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .dbg_i(dbg), .wait_i(wt), .stop_i(stp), .ref_lost_i(lost),
      .irq_o(irq), .rst_timeout_o(rst_to), .rst_window_o(rst_win),
      .rst_refloss_o(rst_rf));

   // {sel, prescale, timeout, tick period in bus cycles}
   localparam int TBL [5][4] = '{
      '{0, 0, 7, 4}, '{1, 0, 7, 8}, '{2, 1, 5, 32}, '{3, 2, 3, 96}, '{0, 3, 9, 16}};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic service();
      wr(3'd5, 16'h5555);
      wr(3'd5, 16'hAAAA);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; dbg = 0; wt = 0; stp = 0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v, c0, c1, w0;
      do_reset();
      // R1 reset state
      rd(3'd6, v); chk(v == 16'hFFFF, "R1 count", v, 16'hFFFF);
      rd(3'd1, v); chk(v == 16'hFFFF, "R1 timeout", v, 16'hFFFF);
      rd(3'd7, v); chk(v == 0, "R1 cause", v, 0);
      chk({irq, rst_to, rst_win, rst_rf} == 4'b0, "R1 outputs", int'({irq, rst_to, rst_win, rst_rf}), 0);

      // R2 R3 timeout period over source select and prescale
      for (int i = 0; i < 5; i++) begin
         int m, p, t;
         do_reset();
         wr(3'd1, 16'(TBL[i][2]));
         wr(3'd4, 16'(TBL[i][1]));
         wr(3'd0, 16'(1 + (TBL[i][0] << 4)));
         p = TBL[i][3];
         t = (TBL[i][2] + 1) * p;
         m = 0;
         while (!rst_to && m < 3000) begin @(negedge clk); m++; end
         chk(m >= t - p - 2 && m <= t + p + 6, "R2 R3 timeout period", m, t);
         cyc(1);
         chk(!rst_to, "R2 single-cycle pulse", int'(rst_to), 0);
         rd(3'd6, v); chk(v >= TBL[i][2] - 1 && v <= TBL[i][2], "R2 reload after timeout", v, TBL[i][2]);
         rd(3'd7, v); chk(v[0] == 1'b1, "R13 timeout cause", v, 1);
      end

      // R4 service reloads; R5 broken unlock
      do_reset();
      wr(3'd1, 16'd200); wr(3'd0, 16'h0001);
      cyc(300);
      service(); rd(3'd6, v);
      chk(v >= 198 && v <= 200, "R4 service reload", v, 200);
      cyc(100);
      rd(3'd6, c0);
      wr(3'd5, 16'h5555); wr(3'd5, 16'h1234); wr(3'd5, 16'hAAAA);
      rd(3'd6, c1);
      chk(c1 <= c0, "R5 broken sequence ignored", c1, c0);
      service(); rd(3'd6, v);
      chk(v >= 198, "R5 sequence recovers", v, 200);
      rd(3'd7, v); chk(v == 0, "R4 no timeout cause", v, 0);

      // R6 window early/late, R13 clear
      do_reset();
      wr(3'd1, 16'd200); wr(3'd2, 16'd100); wr(3'd0, 16'h0003);
      w0 = n_win;
      service(); cyc(2);
      chk(n_win == w0 + 1, "R6 early service window reset", n_win - w0, 1);
      rd(3'd6, v); chk(v < 200 && v > 190, "R6 no reload on early service", v, 199);
      rd(3'd7, v); chk(v == 2, "R13 window cause", v, 2);
      cyc(480);
      rd(3'd6, c0);
      service(); cyc(2);
      chk(n_win == w0 + 1, "R6 late service accepted", n_win - w0, 1);
      rd(3'd6, v); chk(v >= 198, "R6 late service reloads", v, 200);
      wr(3'd7, 16'h0002);
      rd(3'd7, v); chk(v == 0, "R13 write one clears", v, 0);

      // R7 window disabled
      do_reset();
      wr(3'd1, 16'd200); wr(3'd2, 16'd100); wr(3'd0, 16'h0001);
      cyc(200);
      w0 = n_win;
      service(); cyc(2);
      chk(n_win == w0, "R7 no window reset", n_win - w0, 0);
      rd(3'd6, v); chk(v >= 198, "R7 early service reloads", v, 200);

      // R8 interrupt, R12 lock
      do_reset();
      wr(3'd1, 16'd60); wr(3'd3, 16'd20); wr(3'd0, 16'h0041);
      cyc(4);
      chk(!irq, "R8 irq low above level", int'(irq), 0);
      wr(3'd1, 16'h1234); rd(3'd1, v);
      chk(v == 60, "R12 timeout locked", v, 60);
      wr(3'd0, 16'h0000); rd(3'd0, v);
      chk(v[0] == 1'b1, "R12 enable locked", v & 1, 1);
      cyc(170);
      chk(irq, "R8 irq high at level", int'(irq), 1);
      service(); cyc(1);
      chk(!irq, "R8 irq cleared by service", int'(irq), 0);

      // R9 debug freeze
      do_reset();
      wr(3'd1, 16'd200); wr(3'd0, 16'h0001);
      cyc(40); dbg = 1'b1; cyc(2);
      rd(3'd6, c0); cyc(100); rd(3'd6, c1);
      chk(c1 == c0, "R9 frozen in debug", c1, c0);
      dbg = 1'b0; cyc(40); rd(3'd6, v);
      chk(v < c1, "R9 resumes after debug", v, c1 - 10);

      // R10 wait and stop controls
      do_reset();
      wr(3'd1, 16'd200); wr(3'd0, 16'h0001);
      cyc(20); wt = 1'b1; cyc(2);
      rd(3'd6, c0); cyc(80); rd(3'd6, c1);
      chk(c1 == c0, "R10 frozen in wait", c1, c0);
      wt = 1'b0; stp = 1'b1; cyc(2);
      rd(3'd6, c0); cyc(80); rd(3'd6, c1);
      chk(c1 == c0, "R10 frozen in stop", c1, c0);
      do_reset();
      wr(3'd1, 16'd200); wr(3'd0, 16'h000D);
      wt = 1'b1; stp = 1'b1; cyc(2);
      rd(3'd6, c0); cyc(80); rd(3'd6, c1);
      chk(c1 < c0 - 10, "R10 runs when allowed", c1, c0 - 20);

      // R11 reference loss delay
      do_reset();
      begin
         int m, r0;
         r0 = n_rf;
         @(negedge clk); lost = 1'b1;
         @(negedge clk); lost = 1'b0;
         m = 1;
         while (!rst_rf && m < 400) begin @(negedge clk); m++; end
         chk(m == 129, "R11 refloss delay", m, 129);
         cyc(1);
         chk(n_rf == r0 + 1, "R11 single pulse", n_rf - r0, 1);
         rd(3'd7, v); chk(v == 4, "R13 refloss cause", v, 4);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule